// File: doc/BRIEF.md
# Three-Leg Gate Command Interlock

This block sits between a motor-control timer and the gate drivers of a three-leg inverter. Each leg has a high-side and a low-side command input. Both are active-low: a low level requests the transistor on, and an idle, pulled-up line means off. The block turns these commands into registered gate-enable outputs. It guarantees that the two transistors of a leg are never enabled in the same cycle.

Each leg keeps a small owner state. The arm whose request is granted first keeps the leg for as long as its command stays active. A request for the opposite arm is held off during that time and produces no signal of any kind. When the owning command is released and the other request is still present, the leg passes straight to the waiting arm on the next clock edge. No gap is inserted between the two arms, because dead time is the job of the controller that generates the commands. The command inputs must already be synchronous to `clk`.

Top module: `hbi_interlock`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with idle inputs, every bit of `hi_gate` and `lo_gate` is 0 and no arm owns any leg.
- R2: For every leg i, `hi_gate[i]` and `lo_gate[i]` are never 1 in the same cycle.
- R3: On an idle leg, a single active command is granted at the next rising clock edge. The gate returns to 0 at the edge after that command goes inactive.
- R4: While one arm of a leg is on and its command is still active, the opposite arm's gate stays 0 whatever its command does.
- R5: An arm that owns a leg keeps its gate at 1 as long as its command stays active, even when the opposite arm requests on.
- R6: When the owning command goes inactive while the opposite command is active, the opposite gate is 1 at the very next edge. At that same edge the owning gate goes to 0.
- R7: When both commands of an idle leg become active in the same cycle, the low-side arm is granted, because the default `TIE_LOW_WINS` is 1.
- R8: The command inputs are active-low: 0 requests on and 1 means off. An inactive command always drives its gate to 0 at the next edge.
- R9: Bit i of every port vector belongs to leg i (0 = U, 1 = V, 2 = W). The legs behave independently and identically.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_cmd_n | input | NUM_LEGS | High-side commands, active-low, one bit per leg |
| lo_cmd_n | input | NUM_LEGS | Low-side commands, active-low, one bit per leg |
| hi_gate | output | NUM_LEGS | High-side gate enables, registered |
| lo_gate | output | NUM_LEGS | Low-side gate enables, registered |

## Verification
The only state in this block is the owner of each leg, and the two gate outputs show that state directly. A corrupted owner therefore appears at the ports in the same cycle it is taken.

A wrong grant rule shows one edge after the stimulus that exposes it. A stale owner keeps a gate on after its command has gone high. A lost priority memory hands the leg to the second requester while the first still holds its command. A broken replay leaves the waiting gate at 0 after the owner releases.

The bench runs a reference model of each leg's owner and compares both gate vectors after every edge. Directed cases cover ownership, replay and the simultaneous tie, and random traffic covers all three legs at once.

// File: rtl/hbi_pkg.sv
// Shared types for the gate command interlock.
// Assumes nothing beyond the standard enum semantics.
package hbi_pkg;

    // Which arm of a leg currently holds the gate.
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_HIGH = 2'd1,
        OWN_LOW  = 2'd2
    } leg_owner_t;

endpackage

// File: rtl/hbi_cmd_decode.sv
// Converts the active-low command lines of all legs into active-high requests.
// Assumes the inputs are already synchronous to the consuming clock.
module hbi_cmd_decode #(
    parameter int NUM_LEGS = 3
) (
    input  logic [NUM_LEGS-1:0] hi_cmd_n,
    input  logic [NUM_LEGS-1:0] lo_cmd_n,
    output logic [NUM_LEGS-1:0] hi_req,
    output logic [NUM_LEGS-1:0] lo_req
);

    // Invert the polarity: a low command level is an on request.
    always_comb begin
        hi_req = ~hi_cmd_n;
        lo_req = ~lo_cmd_n;
    end

endmodule

// File: rtl/hbi_leg_arbiter.sv
// First-come owner arbitration for one inverter leg.
// The arm that is granted first keeps the leg while its request stays on.
// A blocked request takes the leg at the edge on which the owner releases.
// Assumes active-high, synchronous requests. The gate outputs come straight
// from the owner register, so they are glitch-free and mutually exclusive.
module hbi_leg_arbiter
    import hbi_pkg::*;
#(
    parameter bit TIE_LOW_WINS = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_hi,
    input  logic req_lo,
    output logic gate_hi,
    output logic gate_lo
);

    leg_owner_t owner_q;
    leg_owner_t owner_d;
    leg_owner_t tie_pick;

    // Fixed winner used when both arms ask at once on an idle leg.
    generate
        if (TIE_LOW_WINS) begin : g_tie_low
            assign tie_pick = OWN_LOW;
        end else begin : g_tie_high
            assign tie_pick = OWN_HIGH;
        end
    endgenerate

    // Next owner: keep the current owner, hand over on release, or grant an idle leg.
    always_comb begin
        owner_d = OWN_NONE;
        unique case (owner_q)
            OWN_HIGH: begin
                if (req_hi)      owner_d = OWN_HIGH;
                else if (req_lo) owner_d = OWN_LOW;
            end
            OWN_LOW: begin
                if (req_lo)      owner_d = OWN_LOW;
                else if (req_hi) owner_d = OWN_HIGH;
            end
            default: begin
                if (req_hi && req_lo) owner_d = tie_pick;
                else if (req_hi)      owner_d = OWN_HIGH;
                else if (req_lo)      owner_d = OWN_LOW;
            end
        endcase
    end

    // Owner register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) owner_q <= OWN_NONE;
        else        owner_q <= owner_d;
    end

    // Gate enables decoded from the registered owner.
    always_comb begin
        gate_hi = (owner_q == OWN_HIGH);
        gate_lo = (owner_q == OWN_LOW);
    end

endmodule

// File: rtl/hbi_interlock.sv
// Top level of the three-leg gate command interlock.
// It decodes the active-low commands and gives each leg its own arbiter.
// Assumes synchronous command inputs. Dead time and fault reporting are
// handled elsewhere.
module hbi_interlock #(
    parameter int NUM_LEGS     = 3,
    parameter bit TIE_LOW_WINS = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_LEGS-1:0] hi_cmd_n,
    input  logic [NUM_LEGS-1:0] lo_cmd_n,
    output logic [NUM_LEGS-1:0] hi_gate,
    output logic [NUM_LEGS-1:0] lo_gate
);

    logic [NUM_LEGS-1:0] hi_req;
    logic [NUM_LEGS-1:0] lo_req;

    // Polarity conversion shared by all legs.
    hbi_cmd_decode #(.NUM_LEGS(NUM_LEGS)) decode_i (
        .hi_cmd_n (hi_cmd_n),
        .lo_cmd_n (lo_cmd_n),
        .hi_req   (hi_req),
        .lo_req   (lo_req)
    );

    // One independent arbiter per leg.
    generate
        for (genvar leg = 0; leg < NUM_LEGS; leg++) begin : g_leg
            hbi_leg_arbiter #(.TIE_LOW_WINS(TIE_LOW_WINS)) arb_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .req_hi  (hi_req[leg]),
                .req_lo  (lo_req[leg]),
                .gate_hi (hi_gate[leg]),
                .gate_lo (lo_gate[leg])
            );
        end
    endgenerate

endmodule

// File: rtl/hbi_interlock_checker.sv
// Port-level assertions for the interlock. They are attached to every
// instance of hbi_interlock through the bind statement at the end of this file.
module hbi_interlock_checker #(
    parameter int NUM_LEGS = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_LEGS-1:0] hi_cmd_n,
    input logic [NUM_LEGS-1:0] lo_cmd_n,
    input logic [NUM_LEGS-1:0] hi_gate,
    input logic [NUM_LEGS-1:0] lo_gate
);

    logic rst_seen_q = 1'b0;

    // Remember that reset was low at the previous edge.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    // R1: one edge after reset was sampled low, all gates are off.
    assert_reset_off_R1: assert property (@(posedge clk)
        rst_seen_q |-> (hi_gate == '0 && lo_gate == '0));

    generate
        for (genvar i = 0; i < NUM_LEGS; i++) begin : g_chk
            // R2: the two gates of a leg are never on together.
            assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
                !(hi_gate[i] && lo_gate[i]));

            // R3: a lone high-side request on an idle leg is granted next edge.
            assert_grant_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (!hi_gate[i] && !lo_gate[i] && !hi_cmd_n[i] && lo_cmd_n[i]) |=> hi_gate[i]);

            // R4: a held high-side owner blocks the low side.
            assert_block_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (hi_gate[i] && !hi_cmd_n[i]) |=> !lo_gate[i]);

            // R4: a held low-side owner blocks the high side.
            assert_block_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (lo_gate[i] && !lo_cmd_n[i]) |=> !hi_gate[i]);

            // R5: the owner keeps its gate while its command holds.
            assert_keep_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (lo_gate[i] && !lo_cmd_n[i]) |=> lo_gate[i]);

            // R6: release by the high side hands the leg to a waiting low side.
            assert_replay_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (hi_gate[i] && hi_cmd_n[i] && !lo_cmd_n[i]) |=> lo_gate[i]);

            // R8: an inactive command turns its gate off at the next edge.
            assert_off_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
                hi_cmd_n[i] |=> !hi_gate[i]);
        end
    endgenerate

endmodule

bind hbi_interlock hbi_interlock_checker #(.NUM_LEGS(NUM_LEGS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hi_cmd_n (hi_cmd_n),
    .lo_cmd_n (lo_cmd_n),
    .hi_gate  (hi_gate),
    .lo_gate  (lo_gate)
);

// File: tb/hbi_interlock_tb.sv
// Self-checking bench: directed corner cases, then seeded random traffic,
// all compared against a per-leg owner model.
module hbi_interlock_tb_top;

    localparam int LEGS = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [LEGS-1:0] hi_cmd_n = '1;
    logic [LEGS-1:0] lo_cmd_n = '1;
    logic [LEGS-1:0] hi_gate;
    logic [LEGS-1:0] lo_gate;

    int checks = 0;
    int failures = 0;
    int exp_own [LEGS];   // 0 idle, 1 high side, 2 low side

    always #10ns clk = ~clk;

    hbi_interlock #(.NUM_LEGS(LEGS)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_cmd_n (hi_cmd_n),
        .lo_cmd_n (lo_cmd_n),
        .hi_gate  (hi_gate),
        .lo_gate  (lo_gate)
    );

    // Reference next-owner rule taken from the requirements (low side wins a tie).
    function automatic int next_owner(int cur, bit rh, bit rl);
        if (cur == 1) return rh ? 1 : (rl ? 2 : 0);
        if (cur == 2) return rl ? 2 : (rh ? 1 : 0);
        if (rl) return 2;
        if (rh) return 1;
        return 0;
    endfunction

    task automatic check_vec(string tag, logic [LEGS-1:0] act, logic [LEGS-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Apply commands at a falling edge, let one rising edge pass, then compare.
    task automatic drive(string tag, logic [LEGS-1:0] h_n, logic [LEGS-1:0] l_n);
        logic [LEGS-1:0] eh;
        logic [LEGS-1:0] el;
        hi_cmd_n = h_n;
        lo_cmd_n = l_n;
        @(negedge clk);
        for (int i = 0; i < LEGS; i++) begin
            exp_own[i] = next_owner(exp_own[i], !h_n[i], !l_n[i]);
            eh[i] = (exp_own[i] == 1);
            el[i] = (exp_own[i] == 2);
        end
        check_vec({tag, " hi_gate"}, hi_gate, eh);
        check_vec({tag, " lo_gate"}, lo_gate, el);
        checks++;
        if ((hi_gate & lo_gate) != '0) begin
            failures++;
            $display("FAIL R2 actual=%b expected=000", hi_gate & lo_gate);
        end
    endtask

    initial begin
        #(20ns * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        for (int i = 0; i < LEGS; i++) exp_own[i] = 0;
        // R1: gates stay off while reset is held, even with commands active.
        hi_cmd_n = 3'b010;
        lo_cmd_n = 3'b101;
        repeat (3) @(negedge clk);
        check_vec("R1 reset hi", hi_gate, '0);
        check_vec("R1 reset lo", lo_gate, '0);
        hi_cmd_n = '1;
        lo_cmd_n = '1;
        @(negedge clk);
        rst_n = 1'b1;
        drive("R1 idle after reset", 3'b111, 3'b111);

        // R3 and R8: a lone high-side request on leg U, then its release.
        drive("R3 grant U high", 3'b110, 3'b111);
        drive("R8 release U high", 3'b111, 3'b111);
        // R4: U high owns, then the low side asks and is blocked.
        drive("R3 grant again", 3'b110, 3'b111);
        drive("R4 U low blocked", 3'b110, 3'b110);
        drive("R4 still blocked", 3'b110, 3'b110);
        // R6: the owner releases and the waiting low side takes the same edge.
        drive("R6 replay to low", 3'b111, 3'b110);
        // R5: the low side owns, a high request arrives and the low side keeps it.
        drive("R5 low keeps leg", 3'b110, 3'b110);
        drive("R6 replay to high", 3'b110, 3'b111);
        drive("R8 all off", 3'b111, 3'b111);
        // R7: simultaneous requests on idle leg V, the low side wins.
        drive("R7 tie low wins", 3'b101, 3'b101);
        drive("R8 all off", 3'b111, 3'b111);
        // R9: each leg in a different situation at the same time.
        drive("R9 mixed legs", 3'b010, 3'b100);
        drive("R9 mixed hold", 3'b010, 3'b000);
        drive("R9 mixed release", 3'b111, 3'b000);
        drive("R8 all off", 3'b111, 3'b111);

        // R9: seeded random traffic on all legs, with biased toggling.
        for (int n = 0; n < 3000; n++) begin
            logic [LEGS-1:0] h;
            logic [LEGS-1:0] l;
            h = hi_cmd_n;
            l = lo_cmd_n;
            for (int i = 0; i < LEGS; i++) begin
                if ($urandom_range(0, 3) == 0) h[i] = ~h[i];
                if ($urandom_range(0, 3) == 0) l[i] = ~l[i];
            end
            drive("R9 random", h, l);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule